// File: doc/BRIEF.md
# Register-Mapped Network Port Interface

This block sits beside the register-fetch stage of a single-issue, in-order pipeline. It lets four on-chip networks appear as four ordinary register numbers. Each network has one receive FIFO and one transmit FIFO. When an instruction names a network register as a source, it takes the head word of that network's receive FIFO. When it names one as a destination, its result is queued for that network's transmit FIFO. A copy bit in the instruction can also send the result to network 0, in addition to its normal destination.

The instruction stalls in register fetch if it lacks what it needs. That happens when a source receive FIFO is empty, when a destination transmit FIFO has no room left once earlier instructions' reservations are counted, or when the in-flight tag table is full. Each instruction that writes a network gets a 3-bit sequence tag.

The pipeline reports finished values on several stage-tagged result buses. The block accepts a value from whichever stage first shows the tag of the oldest outstanding network-bound instruction. Values that are ready early but younger are ignored until their turn comes, so network traffic stays in program order.

The network edges are valid/ready streams:
- A receive word transfers on a clock edge where `net_in_valid` and `net_in_ready` are both high. `net_in_ready` is low only while that FIFO is full.
- A transmit word transfers on an edge where `net_out_valid` and `net_out_ready` are both high. While ready is low, the valid flag and the data hold steady.

Top module: `netreg_port`

## Requirements
- R1: Register indices 24, 25, 26 and 27 select networks 0, 1, 2 and 3. Any other source index is not a network: its hit flag is 0 and its operand output is zero.
- R2: A source that names a network shows that network's receive head word on the operand output. The word is removed only on a cycle where the instruction proceeds. If both sources name the same network, both operands get the same single word, and only one word is removed.
- R3: `rf_stall` is high while `rf_valid` is high and any named source network has an empty receive FIFO. It drops on the cycle after a word arrives.
- R4: `rf_stall` is high while a destination network's transmit occupancy plus its reservations equals the depth (4). Each proceeding network-bound instruction reserves one slot in each network it targets, and the slot is held until its value is queued.
- R5: With the copy bit set, the result also goes to network 0. A register destination with the copy bit reaches network 0 only. Destination 25 with the copy bit reaches networks 0 and 1. Destination 24 with the copy bit sends one word.
- R6: `rf_tag` shows the tag the next network-bound instruction receives. It advances by one, modulo 8, only when such an instruction proceeds. With 8 tags outstanding, the next network-bound instruction stalls.
- R7: A value on any result-bus stage whose tag equals the oldest outstanding tag is queued into every network that instruction targets. It appears at `net_out_valid` one cycle later.
- R8: A value whose tag is younger than the oldest outstanding tag is ignored. Outputs appear in program order even when a younger value is ready first.
- R9: A stalled cycle, or a read of an unmapped index, removes nothing from any receive FIFO.
- R10: `net_in_ready[n]` is low exactly when that receive FIFO holds 4 words. A transmit word held under low `net_out_ready` keeps its valid flag and its data.
- R11: After reset, all FIFOs are empty: `net_in_ready` is all ones, `net_out_valid` is all zeros, and `rf_tag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rf_valid | input | 1 | An instruction is in register fetch |
| rf_src_a | input | 5 | First source register index |
| rf_src_b | input | 5 | Second source register index |
| rf_dst | input | 5 | Destination register index |
| rf_dst_en | input | 1 | Instruction writes a destination |
| rf_copy0 | input | 1 | Also send result to network 0 |
| rf_stall | output | 1 | Hold the instruction in register fetch |
| rf_opnd_a | output | 32 | Network word for source A (zero if unmapped) |
| rf_opnd_b | output | 32 | Network word for source B (zero if unmapped) |
| rf_hit_a | output | 1 | Source A names a network |
| rf_hit_b | output | 1 | Source B names a network |
| rf_tag | output | 3 | Tag for the next network-bound instruction |
| res_valid | input | 3 | Per-stage result valid |
| res_tag | input | 9 | Per-stage result tag, 3 bits per stage |
| res_data | input | 96 | Per-stage result value, 32 bits per stage |
| net_in_valid | input | 4 | Receive word valid, per network |
| net_in_ready | output | 4 | Receive FIFO can accept, per network |
| net_in_data | input | 128 | Receive words, 32 bits per network |
| net_out_valid | output | 4 | Transmit word available, per network |
| net_out_ready | input | 4 | Network accepts transmit word |
| net_out_data | output | 128 | Transmit head words, 32 bits per network |

## Verification
Results are fed in several patterns:
- In order on one stage, which separates correct queueing from lost words.
- Young before old on different stages, which shows whether the block wrongly lets the newest value win, as a normal bypass would.
- With the copy bit on register and network destinations, which checks single versus double delivery.

Stall behaviour is probed three ways: with an empty source, with a transmit FIFO blocked by back-pressure until reservations reach the depth, and with all eight tags outstanding. Each case shows whether the stall comes from the right resource and whether a stalled instruction leaves its receive word in place.

// File: rtl/netreg_pkg.sv
package netreg_pkg;
  localparam int unsigned NP_NETS   = 4;
  localparam int unsigned NP_WIDTH  = 32;
  localparam int unsigned NP_DEPTH  = 4;
  localparam int unsigned NP_TAG_W  = 3;
  localparam int unsigned NP_STAGES = 3;
  localparam int unsigned NP_IDX_W  = 5;
  localparam int unsigned NP_BASE   = 24;
endpackage

// File: rtl/nrp_fifo.sv
module nrp_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          full_q, empty_q, do_push, do_pop;

  assign do_push = push && !full_q;
  assign do_pop  = pop && !empty_q;
  assign cnt_nxt = cnt_q + CW'(do_push) - CW'(do_pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      if (do_push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
      if (do_pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
      cnt_q   <= cnt_nxt;
      full_q  <= (cnt_nxt == CW'(DEPTH));
      empty_q <= (cnt_nxt == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data;
  end

  assign head  = mem[rd_q];
  assign full  = full_q;
  assign empty = empty_q;
  assign count = cnt_q;
endmodule

// File: rtl/nrp_seqtrack.sv
module nrp_seqtrack #(
  parameter int unsigned NETS   = 4,
  parameter int unsigned W      = 32,
  parameter int unsigned TAG_W  = 3,
  parameter int unsigned STAGES = 3,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned SLOTS = 1 << TAG_W,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  alloc,
  input  logic [NETS-1:0]       alloc_mask,
  output logic [TAG_W-1:0]      alloc_tag,
  output logic                  table_full,
  input  logic [STAGES-1:0]     res_valid,
  input  logic [STAGES*TAG_W-1:0] res_tag,
  input  logic [STAGES*W-1:0]   res_data,
  output logic                  ret_valid,
  output logic [NETS-1:0]       ret_mask,
  output logic [W-1:0]          ret_data,
  output logic [NETS*CW-1:0]    resv_f
);
  logic [NETS-1:0]  mask_tab [SLOTS];
  logic [TAG_W-1:0] tail_q, head_q;
  logic [TAG_W:0]   live_q;
  logic [CW-1:0]    resv_q [NETS];

  // only the oldest outstanding tag can retire; the first stage showing it wins
  always_comb begin
    ret_valid = 1'b0;
    ret_data  = '0;
    for (int s = 0; s < STAGES; s++) begin
      if (!ret_valid && res_valid[s] && live_q != '0 &&
          res_tag[s*TAG_W +: TAG_W] == head_q) begin
        ret_valid = 1'b1;
        ret_data  = res_data[s*W +: W];
      end
    end
  end

  assign ret_mask   = mask_tab[head_q];
  assign alloc_tag  = tail_q;
  assign table_full = (live_q == (TAG_W+1)'(SLOTS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_q <= '0;
      head_q <= '0;
      live_q <= '0;
      for (int i = 0; i < SLOTS; i++) mask_tab[i] <= '0;
      for (int n = 0; n < NETS; n++) resv_q[n] <= '0;
    end else begin
      if (alloc) begin
        mask_tab[tail_q] <= alloc_mask;
        tail_q <= tail_q + TAG_W'(1);
      end
      if (ret_valid) head_q <= head_q + TAG_W'(1);
      live_q <= live_q + (TAG_W+1)'(alloc) - (TAG_W+1)'(ret_valid);
      for (int n = 0; n < NETS; n++)
        resv_q[n] <= resv_q[n] + CW'(alloc && alloc_mask[n])
                               - CW'(ret_valid && ret_mask[n]);
    end
  end

  generate
    for (genvar n = 0; n < NETS; n++) begin : g_resv
      assign resv_f[n*CW +: CW] = resv_q[n];
    end
  endgenerate
endmodule

// File: rtl/netreg_port.sv
module netreg_port
  import netreg_pkg::*;
#(
  parameter int unsigned NETS   = NP_NETS,
  parameter int unsigned W      = NP_WIDTH,
  parameter int unsigned DEPTH  = NP_DEPTH,
  parameter int unsigned TAG_W  = NP_TAG_W,
  parameter int unsigned STAGES = NP_STAGES,
  parameter int unsigned IDX_W  = NP_IDX_W,
  parameter int unsigned BASE   = NP_BASE
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rf_valid,
  input  logic [IDX_W-1:0]        rf_src_a,
  input  logic [IDX_W-1:0]        rf_src_b,
  input  logic [IDX_W-1:0]        rf_dst,
  input  logic                    rf_dst_en,
  input  logic                    rf_copy0,
  output logic                    rf_stall,
  output logic [W-1:0]            rf_opnd_a,
  output logic [W-1:0]            rf_opnd_b,
  output logic                    rf_hit_a,
  output logic                    rf_hit_b,
  output logic [TAG_W-1:0]        rf_tag,
  input  logic [STAGES-1:0]       res_valid,
  input  logic [STAGES*TAG_W-1:0] res_tag,
  input  logic [STAGES*W-1:0]     res_data,
  input  logic [NETS-1:0]         net_in_valid,
  output logic [NETS-1:0]         net_in_ready,
  input  logic [NETS*W-1:0]       net_in_data,
  output logic [NETS-1:0]         net_out_valid,
  input  logic [NETS-1:0]         net_out_ready,
  output logic [NETS*W-1:0]       net_out_data
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [NETS-1:0]   sel_a, sel_b, sel_d, dst_mask, need_src, over;
  logic [NETS-1:0]   in_full, in_empty, out_full, out_empty, pop_in, push_out;
  logic [NETS*W-1:0] in_head;
  logic [NETS*CW-1:0] in_cnt_f, out_cnt_f, resv_f;
  logic              tbl_full, fire, ret_valid;
  logic [NETS-1:0]   ret_mask;
  logic [W-1:0]      ret_data;

  generate
    for (genvar n = 0; n < NETS; n++) begin : g_net
      localparam logic [IDX_W-1:0] IDXN = IDX_W'(BASE + n);
      assign sel_a[n] = (rf_src_a == IDXN);
      assign sel_b[n] = (rf_src_b == IDXN);
      assign sel_d[n] = rf_dst_en && (rf_dst == IDXN);
      assign over[n]  = dst_mask[n] &&
          ((CW+1)'(out_cnt_f[n*CW +: CW]) + (CW+1)'(resv_f[n*CW +: CW]) >= (CW+1)'(DEPTH));

      nrp_fifo #(.W(W), .DEPTH(DEPTH)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .push(net_in_valid[n]), .push_data(net_in_data[n*W +: W]),
        .pop(pop_in[n]), .head(in_head[n*W +: W]),
        .full(in_full[n]), .empty(in_empty[n]), .count(in_cnt_f[n*CW +: CW])
      );

      nrp_fifo #(.W(W), .DEPTH(DEPTH)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .push(push_out[n]), .push_data(ret_data),
        .pop(net_out_ready[n]), .head(net_out_data[n*W +: W]),
        .full(out_full[n]), .empty(out_empty[n]), .count(out_cnt_f[n*CW +: CW])
      );
    end
  endgenerate

  always_comb begin
    dst_mask    = sel_d;
    dst_mask[0] = sel_d[0] | rf_copy0;
    need_src    = sel_a | sel_b;
    rf_opnd_a   = '0;
    rf_opnd_b   = '0;
    for (int n = 0; n < NETS; n++) begin
      if (sel_a[n]) rf_opnd_a = rf_opnd_a | in_head[n*W +: W];
      if (sel_b[n]) rf_opnd_b = rf_opnd_b | in_head[n*W +: W];
    end
  end

  assign rf_stall = rf_valid && ((|(need_src & in_empty)) || (|over) ||
                                 ((|dst_mask) && tbl_full));
  assign fire     = rf_valid && !rf_stall;
  assign pop_in   = need_src & {NETS{fire}};
  assign rf_hit_a = |sel_a;
  assign rf_hit_b = |sel_b;
  assign push_out = ret_mask & {NETS{ret_valid}};
  assign net_in_ready  = ~in_full;
  assign net_out_valid = ~out_empty;

  nrp_seqtrack #(.NETS(NETS), .W(W), .TAG_W(TAG_W), .STAGES(STAGES), .DEPTH(DEPTH)) u_trk (
    .clk(clk), .rst_n(rst_n),
    .alloc(fire && (|dst_mask)), .alloc_mask(dst_mask),
    .alloc_tag(rf_tag), .table_full(tbl_full),
    .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
    .ret_valid(ret_valid), .ret_mask(ret_mask), .ret_data(ret_data),
    .resv_f(resv_f)
  );
endmodule

// File: rtl/netreg_port_chk.sv
module netreg_port_chk #(
  parameter int unsigned NETS  = 4,
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned TAG_W = 3,
  parameter int unsigned IDX_W = 5,
  parameter int unsigned BASE  = 24,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rf_valid,
  input logic               rf_stall,
  input logic [IDX_W-1:0]   rf_dst,
  input logic               rf_dst_en,
  input logic               rf_copy0,
  input logic [TAG_W-1:0]   rf_tag,
  input logic [NETS-1:0]    net_in_ready,
  input logic [NETS-1:0]    net_out_valid,
  input logic [NETS-1:0]    net_out_ready,
  input logic [NETS*W-1:0]  net_out_data,
  input logic [NETS*CW-1:0] in_cnt_f,
  input logic [NETS*CW-1:0] out_cnt_f,
  input logic [NETS*CW-1:0] resv_f,
  input logic [NETS-1:0]    push_out,
  input logic [NETS-1:0]    out_full
);
  logic net_fire;
  assign net_fire = rf_valid && !rf_stall &&
      (rf_copy0 || (rf_dst_en && rf_dst >= IDX_W'(BASE) && rf_dst < IDX_W'(BASE + NETS)));

  // R6
  tag_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    net_fire |=> rf_tag == $past(rf_tag) + TAG_W'(1));
  // R6
  tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !net_fire |=> $stable(rf_tag));

  generate
    for (genvar n = 0; n < NETS; n++) begin : g_chk
      // R10
      out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        net_out_valid[n] && !net_out_ready[n] |=>
          net_out_valid[n] && $stable(net_out_data[n*W +: W]));
      // R4
      no_overbook_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (CW+1)'(out_cnt_f[n*CW +: CW]) + (CW+1)'(resv_f[n*CW +: CW]) <= (CW+1)'(DEPTH));
      // R4
      no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_out[n] && out_full[n]));
      // R9
      stall_keeps_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_valid && rf_stall |=> in_cnt_f[n*CW +: CW] >= $past(in_cnt_f[n*CW +: CW]));
      // R10
      rx_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !net_in_ready[n] |-> in_cnt_f[n*CW +: CW] == CW'(DEPTH));
    end
  endgenerate
endmodule

bind netreg_port netreg_port_chk #(
  .NETS(NETS), .W(W), .DEPTH(DEPTH), .TAG_W(TAG_W), .IDX_W(IDX_W), .BASE(BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rf_valid(rf_valid), .rf_stall(rf_stall),
  .rf_dst(rf_dst), .rf_dst_en(rf_dst_en), .rf_copy0(rf_copy0), .rf_tag(rf_tag),
  .net_in_ready(net_in_ready), .net_out_valid(net_out_valid),
  .net_out_ready(net_out_ready), .net_out_data(net_out_data),
  .in_cnt_f(in_cnt_f), .out_cnt_f(out_cnt_f), .resv_f(resv_f),
  .push_out(push_out), .out_full(out_full)
);

// File: tb/netreg_port_test.sv
module netreg_port_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n;
  logic         rf_valid, rf_dst_en, rf_copy0, rf_stall, rf_hit_a, rf_hit_b;
  logic [4:0]   rf_src_a, rf_src_b, rf_dst;
  logic [31:0]  rf_opnd_a, rf_opnd_b;
  logic [2:0]   rf_tag;
  logic [2:0]   res_valid;
  logic [8:0]   res_tag;
  logic [95:0]  res_data;
  logic [3:0]   net_in_valid, net_in_ready, net_out_valid, net_out_ready;
  logic [127:0] net_in_data, net_out_data;

  netreg_port uut (
    .clk(clk), .rst_n(rst_n), .rf_valid(rf_valid), .rf_src_a(rf_src_a),
    .rf_src_b(rf_src_b), .rf_dst(rf_dst), .rf_dst_en(rf_dst_en),
    .rf_copy0(rf_copy0), .rf_stall(rf_stall), .rf_opnd_a(rf_opnd_a),
    .rf_opnd_b(rf_opnd_b), .rf_hit_a(rf_hit_a), .rf_hit_b(rf_hit_b),
    .rf_tag(rf_tag), .res_valid(res_valid), .res_tag(res_tag),
    .res_data(res_data), .net_in_valid(net_in_valid),
    .net_in_ready(net_in_ready), .net_in_data(net_in_data),
    .net_out_valid(net_out_valid), .net_out_ready(net_out_ready),
    .net_out_data(net_out_data)
  );

  int checks = 0;
  int fails  = 0;
  logic [2:0]  tb_tag = '0;
  logic [3:0]  tb_mask [8];
  logic [31:0] exp_q [4][$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: every transmit transfer is compared against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      for (int n = 0; n < 4; n++) begin
        if (net_out_valid[n] && net_out_ready[n]) begin
          logic [31:0] e;
          if (exp_q[n].size() == 0) chk(1'b0, "R7 unexpected transmit word", net_out_data[n*32 +: 32], 32'h0);
          else begin
            e = exp_q[n].pop_front();
            chk(net_out_data[n*32 +: 32] == e, "R7/R8 transmit order", net_out_data[n*32 +: 32], e);
          end
        end
      end
    end
  end

  function automatic logic [3:0] mask_of(input logic [4:0] d, input bit den, input bit cp);
    mask_of = '0;
    if (den && d >= 5'd24 && d <= 5'd27) mask_of[d - 5'd24] = 1'b1;
    if (cp) mask_of[0] = 1'b1;
  endfunction

  task automatic drive_rf(input logic [4:0] a, input logic [4:0] b, input logic [4:0] d, input bit den, input bit cp);
    rf_valid = 1'b1; rf_src_a = a; rf_src_b = b; rf_dst = d; rf_dst_en = den; rf_copy0 = cp;
  endtask

  task automatic end_rf();
    @(posedge clk); #1;
    rf_valid = 1'b0;
  endtask

  task automatic issue(input logic [4:0] a, input logic [4:0] b, input logic [4:0] d, input bit den, input bit cp);
    logic [3:0] m;
    m = mask_of(d, den, cp);
    drive_rf(a, b, d, den, cp);
    @(negedge clk);
    chk(!rf_stall, "R3/R4 unexpected stall", 32'(rf_stall), 32'h0);
    chk(rf_tag == tb_tag, "R6 issued tag", 32'(rf_tag), 32'(tb_tag));
    if (m != '0) begin tb_mask[tb_tag] = m; tb_tag = tb_tag + 3'd1; end
    end_rf();
  endtask

  task automatic push_in(input int n, input logic [31:0] d);
    net_in_valid[n] = 1'b1; net_in_data[n*32 +: 32] = d;
    @(posedge clk); #1;
    net_in_valid[n] = 1'b0;
  endtask

  task automatic present(input int s, input logic [2:0] t, input logic [31:0] d);
    res_valid[s] = 1'b1; res_tag[s*3 +: 3] = t; res_data[s*32 +: 32] = d;
    @(posedge clk); #1;
    res_valid[s] = 1'b0;
  endtask

  // driver: queue expected words for every network this tag targets, then present it
  task automatic finish(input int s, input logic [2:0] t, input logic [31:0] d);
    for (int n = 0; n < 4; n++) if (tb_mask[t][n]) exp_q[n].push_back(d);
    present(s, t, d);
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [2:0] t0, t1;
    logic [2:0] tq [8];
    rst_n = 1'b0; rf_valid = 1'b0; rf_src_a = '0; rf_src_b = '0; rf_dst = '0;
    rf_dst_en = 1'b0; rf_copy0 = 1'b0; res_valid = '0; res_tag = '0; res_data = '0;
    net_in_valid = '0; net_in_data = '0; net_out_ready = 4'hF;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11 reset state
    @(negedge clk);
    chk(net_in_ready == 4'hF, "R11 rx ready after reset", 32'(net_in_ready), 32'hF);
    chk(net_out_valid == 4'h0, "R11 tx valid after reset", 32'(net_out_valid), 32'h0);
    chk(rf_tag == 3'd0, "R11 tag after reset", 32'(rf_tag), 32'h0);
    @(posedge clk); #1;

    // R1 unmapped indices
    drive_rf(5'd23, 5'd28, 5'd0, 1'b0, 1'b0);
    @(negedge clk);
    chk(!rf_hit_a && !rf_hit_b, "R1 unmapped hit", {30'b0, rf_hit_a, rf_hit_b}, 32'h0);
    chk(rf_opnd_a == 32'h0, "R1 unmapped operand", rf_opnd_a, 32'h0);
    end_rf();

    // R2 same network on both sources takes one word
    push_in(1, 32'hA1A1_0001);
    push_in(1, 32'hA1A1_0002);
    drive_rf(5'd25, 5'd25, 5'd1, 1'b1, 1'b0);
    @(negedge clk);
    chk(rf_hit_a && rf_opnd_a == 32'hA1A1_0001, "R2 operand A head", rf_opnd_a, 32'hA1A1_0001);
    chk(rf_opnd_b == 32'hA1A1_0001, "R2 operand B same word", rf_opnd_b, 32'hA1A1_0001);
    end_rf();
    // R9 unmapped read leaves the next word in place
    drive_rf(5'd5, 5'd6, 5'd1, 1'b1, 1'b0);
    @(negedge clk);
    end_rf();
    drive_rf(5'd25, 5'd0, 5'd1, 1'b1, 1'b0);
    @(negedge clk);
    chk(rf_opnd_a == 32'hA1A1_0002, "R2/R9 second word", rf_opnd_a, 32'hA1A1_0002);
    end_rf();

    // R3 stall on empty source, release on arrival
    drive_rf(5'd26, 5'd0, 5'd2, 1'b1, 1'b0);
    @(negedge clk);
    chk(rf_stall, "R3 stall on empty source", 32'(rf_stall), 32'h1);
    repeat (2) @(negedge clk);
    chk(rf_stall, "R3 stall held", 32'(rf_stall), 32'h1);
    @(posedge clk); #1;
    push_in(2, 32'hB2B2_0001);
    @(negedge clk);
    chk(!rf_stall && rf_opnd_a == 32'hB2B2_0001, "R3 release with word", rf_opnd_a, 32'hB2B2_0001);
    end_rf();

    // R10 receive ready low when full
    for (int i = 0; i < 4; i++) push_in(3, 32'hC3C3_0000 + 32'(i));
    @(negedge clk);
    chk(net_in_ready[3] == 1'b0, "R10 rx ready low when full", 32'(net_in_ready[3]), 32'h0);
    @(posedge clk); #1;
    issue(5'd27, 5'd0, 5'd1, 1'b1, 1'b0);
    @(negedge clk);
    chk(net_in_ready[3] == 1'b1, "R10 rx ready after read", 32'(net_in_ready[3]), 32'h1);
    @(posedge clk); #1;

    // R7 basic forwarding from a middle stage
    t0 = tb_tag;
    issue(5'd0, 5'd0, 5'd27, 1'b1, 1'b0);
    finish(1, t0, 32'hD000_0001);
    @(negedge clk);
    chk(net_out_valid[3], "R7 result reaches network 3", 32'(net_out_valid[3]), 32'h1);
    @(posedge clk); #1;

    // R8 younger ready first is ignored
    t0 = tb_tag; issue(5'd0, 5'd0, 5'd24, 1'b1, 1'b0);
    t1 = tb_tag; issue(5'd0, 5'd0, 5'd25, 1'b1, 1'b0);
    present(0, t1, 32'hE000_0002);
    @(negedge clk);
    chk(net_out_valid[1] == 1'b0, "R8 younger value held back", 32'(net_out_valid[1]), 32'h0);
    @(posedge clk); #1;
    finish(1, t0, 32'hE000_0001);
    finish(2, t1, 32'hE000_0002);

    // R5 copy bit
    t0 = tb_tag; issue(5'd0, 5'd0, 5'd3, 1'b1, 1'b1);
    finish(0, t0, 32'hF000_0001);
    t0 = tb_tag; issue(5'd0, 5'd0, 5'd25, 1'b1, 1'b1);
    finish(2, t0, 32'hF000_0002);
    t0 = tb_tag; issue(5'd0, 5'd0, 5'd24, 1'b1, 1'b1);
    finish(1, t0, 32'hF000_0003);
    repeat (4) @(posedge clk);
    #1;
    chk(exp_q[0].size() == 0 && exp_q[1].size() == 0, "R5 copy delivery count",
        32'(exp_q[0].size() + exp_q[1].size()), 32'h0);

    // R4 reservation stall under back-pressure
    net_out_ready[2] = 1'b0;
    for (int i = 0; i < 4; i++) begin tq[i] = tb_tag; issue(5'd0, 5'd0, 5'd26, 1'b1, 1'b0); end
    push_in(0, 32'h5151_0001);
    push_in(0, 32'h5151_0002);
    drive_rf(5'd24, 5'd0, 5'd26, 1'b1, 1'b0);
    @(negedge clk);
    chk(rf_stall, "R4 stall when reservations fill", 32'(rf_stall), 32'h1);
    chk(rf_opnd_a == 32'h5151_0001, "R9 stalled read shows head", rf_opnd_a, 32'h5151_0001);
    @(posedge clk); #1;
    for (int i = 0; i < 4; i++) finish(0, tq[i], 32'h7000_0000 + 32'(i));
    @(negedge clk);
    chk(rf_stall, "R4 stall while tx full", 32'(rf_stall), 32'h1);
    @(posedge clk); #1;
    net_out_ready[2] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(!rf_stall, "R4 stall clears after drain", 32'(rf_stall), 32'h0);
    chk(rf_tag == tb_tag, "R6 tag at release", 32'(rf_tag), 32'(tb_tag));
    t0 = tb_tag; tb_mask[t0] = 4'b0100; tb_tag = tb_tag + 3'd1;
    end_rf();
    finish(0, t0, 32'h7000_0004);
    drive_rf(5'd24, 5'd0, 5'd1, 1'b1, 1'b0);
    @(negedge clk);
    chk(rf_opnd_a == 32'h5151_0002, "R9 stalled cycle did not dequeue", rf_opnd_a, 32'h5151_0002);
    end_rf();
    repeat (6) @(posedge clk);
    #1;

    // R6 tag table full
    for (int i = 0; i < 8; i++) begin
      tq[i] = tb_tag;
      issue(5'd0, 5'd0, (i < 4) ? 5'd24 : 5'd25, 1'b1, 1'b0);
    end
    drive_rf(5'd0, 5'd0, 5'd27, 1'b1, 1'b0);
    @(negedge clk);
    chk(rf_stall, "R6 stall with eight tags out", 32'(rf_stall), 32'h1);
    @(posedge clk); #1;
    finish(2, tq[0], 32'h9000_0000);
    @(negedge clk);
    chk(!rf_stall, "R6 stall clears after retire", 32'(rf_stall), 32'h0);
    chk(rf_tag == tb_tag, "R6 reused tag", 32'(rf_tag), 32'(tb_tag));
    t0 = tb_tag; tb_mask[t0] = 4'b1000; tb_tag = tb_tag + 3'd1;
    end_rf();
    for (int i = 1; i < 8; i++) finish(i % 3, tq[i], 32'h9000_0000 + 32'(i));
    finish(0, t0, 32'h9000_0008);

    repeat (10) @(posedge clk);
    #1;
    for (int n = 0; n < 4; n++)
      chk(exp_q[n].size() == 0, "R7 all expected words delivered", 32'(exp_q[n].size()), 32'h0);
    chk(net_out_valid == 4'h0, "R7 transmit FIFOs drained", 32'(net_out_valid), 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule